// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block runs the clocked burst-read path of a 16-bit NOR-style memory. A word address is captured on the clock edge where the address-valid strobe is high while the chip is enabled. The sequencer then counts out a programmable first-access latency. After that it walks the word address through the burst, presenting one read request per word to an internal array port. It raises a data-valid indication for as long as each word is meant to be held on the bus.

A set of read-configuration fields controls the burst:

- the burst length;
- wrapping versus linear addressing;
- a one- or two-clock data hold;
- the latency code;
- the wait handshake's polarity and timing.

All fields except the wait polarity are sampled together with the start address, so a burst in flight is not disturbed by later changes. The wait output is only driven while both the chip enable and the output enable are high. Otherwise its enable output is low, which stands in for a high-impedance pin. Dropping the chip enable ends any burst at once.

Top module: `burst_read_seq`

## Requirements
- R1: After reset, `data_valid`, `arr_rd` and `lat_illegal` are low and the sequencer is idle.
- R2: Counting the edge that samples the strobe as edge 1, the first word appears (`data_valid` high) right after edge L, where L is the latency code. Codes 0 and 1 are reserved. They act as the largest code (7 with the default 3-bit field) and set `lat_illegal` from the strobe edge. `lat_illegal` stays set until a strobe with a legal code.
- R3: `cfg_len` encodes the burst length as 0 = 4 words, 1 = 8 words, 2 = 16 words, 3 = continuous. A fixed-length burst delivers exactly that many words, then returns to idle with `data_valid` low.
- R4: With `cfg_no_wrap` = 1, each following word address is the previous one plus one, freely crossing aligned length boundaries.
- R5: With `cfg_no_wrap` = 0 and a fixed length N, the next address keeps every bit above the low log2(N) bits and increments only those low bits modulo N.
- R6: A continuous burst always counts linearly whatever `cfg_no_wrap` says, and runs until the chip enable drops.
- R7: With `cfg_hold2` = 1, each word holds `data_valid` and `arr_addr` for two cycles and `arr_rd` pulses only in the first. With `cfg_hold2` = 0, each word lasts one cycle.
- R8: `cfg_wait_hi` = 1 makes `wait_out` high while waiting and low otherwise; `cfg_wait_hi` = 0 inverts both levels.
- R9: With `cfg_wait_early` = 0, the wait condition is active in every latency cycle. With `cfg_wait_early` = 1, it is released one cycle before the first word.
- R10: `wait_oe` is high exactly when `chip_en` and `out_en` are both high; `wait_out` is low whenever `wait_oe` is low.
- R11: In any cycle where `chip_en` is low, `data_valid` and `arr_rd` are low. The burst is then abandoned, and re-enabling the chip does not resume it.
- R12: Length, wrap, hold, wait-timing and latency fields are taken only at the strobe edge; changing them during a burst has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Chip enable, active high |
| out_en | input | 1 | Output enable, active high |
| addr_valid | input | 1 | Start-address strobe |
| start_addr | input | ADDR_W | Burst start word address |
| cfg_len | input | 2 | Burst length code |
| cfg_no_wrap | input | 1 | 1 = linear, 0 = wrap in window |
| cfg_hold2 | input | 1 | 1 = two-clock data hold |
| cfg_wait_hi | input | 1 | Wait polarity, 1 = active high |
| cfg_wait_early | input | 1 | 1 = release wait one cycle early |
| cfg_lat_code | input | LAT_W | First-access latency code |
| arr_addr | output | ADDR_W | Word address to array port |
| arr_rd | output | 1 | Array read request, one per word |
| data_valid | output | 1 | Current word valid on the bus |
| wait_out | output | 1 | Wait handshake level |
| wait_oe | output | 1 | Wait drive enable (low = high-impedance) |
| lat_illegal | output | 1 | Last strobe used a reserved latency code |

## Verification
A corrupted latency counter moves the first rise of `data_valid` off its expected edge. A bad count is therefore visible within at most seven cycles of the strobe. An error in the address or word counter shows on `arr_addr` at the very next word. It can also appear as a burst that ends one word early or late, which is seen on the cycle after the final word. A stale or wrongly latched configuration shows within the burst, through hold length, wrap point or wait release timing. The bench scrambles every sampled field right after each strobe, so such a fault is caught in the same burst.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic [1:0] {
        BL_4    = 2'd0,
        BL_8    = 2'd1,
        BL_16   = 2'd2,
        BL_CONT = 2'd3
    } blen_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LAT  = 2'd1,
        ST_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        blen_e len;
        logic  no_wrap;
        logic  hold2;
        logic  wait_early;
    } bcfg_t;

    localparam bcfg_t CFG_RESET = '{len: BL_CONT, no_wrap: 1'b1, hold2: 1'b1, wait_early: 1'b0};

    // Words in a fixed burst; zero means unbounded.
    function automatic logic [4:0] words_of(blen_e l);
        case (l)
            BL_4:    return 5'd4;
            BL_8:    return 5'd8;
            BL_16:   return 5'd16;
            default: return 5'd0;
        endcase
    endfunction

    function automatic logic is_linear(bcfg_t c);
        return (c.len == BL_CONT) || c.no_wrap;
    endfunction

endpackage

// File: rtl/bseq_cfg_latch.sv
module bseq_cfg_latch
    import bseq_pkg::*;
#(
    parameter int LAT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  bcfg_t            cfg_in,
    input  logic [LAT_W-1:0] lat_code,
    output bcfg_t            cfg_q,
    output logic [LAT_W-1:0] lat_dec,
    output logic             lat_bad
);
    localparam logic [LAT_W-1:0] LAT_MAX = '1;
    localparam logic [LAT_W-1:0] LAT_MIN = LAT_W'(2);

    logic code_rsv;
    assign code_rsv = (lat_code < LAT_MIN);
    assign lat_dec  = code_rsv ? LAT_MAX : lat_code;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= CFG_RESET;
            lat_bad <= 1'b0;
        end else if (load) begin
            cfg_q   <= cfg_in;
            lat_bad <= code_rsv;
        end
    end

    // R2: a reserved code on a strobe is recorded
    p_illegal_r2: assert property (@(posedge clk) disable iff (rst)
        (load && (lat_code == '0)) |=> lat_bad);

    // R12: sampled fields only move on a strobe
    p_cfg_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cfg_q));

endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 23
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] start,
    input  logic              adv,
    input  blen_e             len,
    input  logic              linear,
    output logic [ADDR_W-1:0] addr_q,
    output logic              last
);
    localparam int CNT_W = 4;

    logic [CNT_W-1:0]  cnt_q;
    logic [4:0]        words;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] inc;
    logic [ADDR_W-1:0] nxt;

    assign words = words_of(len);
    assign mask  = ADDR_W'(words) - ADDR_W'(1);
    assign inc   = addr_q + ADDR_W'(1);
    assign nxt   = linear ? inc : ((addr_q & ~mask) | (inc & mask));
    assign last  = (len != BL_CONT) && ({1'b0, cnt_q} == (words - 5'd1));

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            addr_q <= start;
            cnt_q  <= '0;
        end else if (adv) begin
            addr_q <= nxt;
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

    // R4: linear stepping
    p_linear_r4: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && linear) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));

    // R5: wrapping never touches bits above the window
    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && !linear) |=> (((addr_q ^ $past(addr_q)) & ~$past(mask)) == '0));

    // R6: continuous bursts always count up
    p_cont_r6: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && (len == BL_CONT)) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));

endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
    import bseq_pkg::*;
#(
    parameter int LAT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chip_en,
    input  logic             strobe,
    input  logic [LAT_W-1:0] lat_dec,
    input  logic             hold2,
    input  logic             wait_early,
    input  logic             last,
    output phase_e           st_q,
    output logic             ph_q,
    output logic             adv,
    output logic             wait_act
);
    logic [LAT_W-1:0] cnt_q;

    assign adv      = chip_en && !strobe && (st_q == ST_DATA) && (ph_q || !hold2);
    assign wait_act = chip_en && (st_q == ST_LAT) && !(wait_early && (cnt_q == LAT_W'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            ph_q  <= 1'b0;
        end else if (!chip_en) begin
            st_q <= ST_IDLE;
            ph_q <= 1'b0;
        end else if (strobe) begin
            st_q  <= ST_LAT;
            cnt_q <= lat_dec - LAT_W'(1);
            ph_q  <= 1'b0;
        end else begin
            case (st_q)
                ST_LAT: begin
                    if (cnt_q == LAT_W'(1)) st_q <= ST_DATA;
                    else                    cnt_q <= cnt_q - LAT_W'(1);
                end
                ST_DATA: begin
                    if (hold2 && !ph_q) begin
                        ph_q <= 1'b1;
                    end else begin
                        ph_q <= 1'b0;
                        if (last) st_q <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R2: latency counter never sits at zero while counting
    p_lat_cnt_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LAT) |-> (cnt_q != '0));

    // R7: first half of a held word is followed by the second half
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_DATA) && hold2 && !ph_q && chip_en && !strobe) |=> ((st_q == ST_DATA) && ph_q));

    // R3: final word of a fixed burst returns to idle
    p_end_r3: assert property (@(posedge clk) disable iff (rst)
        (adv && last) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/bseq_wait_drv.sv
module bseq_wait_drv (
    input  logic chip_en,
    input  logic out_en,
    input  logic wait_act,
    input  logic wait_hi,
    output logic wait_out,
    output logic wait_oe
);
    assign wait_oe  = chip_en && out_en;
    assign wait_out = wait_oe && (wait_act == wait_hi);
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 23,
    parameter int LAT_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_en,
    input  logic              out_en,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_no_wrap,
    input  logic              cfg_hold2,
    input  logic              cfg_wait_hi,
    input  logic              cfg_wait_early,
    input  logic [LAT_W-1:0]  cfg_lat_code,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              arr_rd,
    output logic              data_valid,
    output logic              wait_out,
    output logic              wait_oe,
    output logic              lat_illegal
);
    bcfg_t            cfg_in;
    bcfg_t            cfg_q;
    logic [LAT_W-1:0] lat_dec;
    logic             strobe;
    logic             adv;
    logic             last;
    logic             wait_act;
    logic             ph_q;
    phase_e           st_q;

    assign strobe = addr_valid && chip_en;

    always_comb begin
        cfg_in.len        = blen_e'(cfg_len);
        cfg_in.no_wrap    = cfg_no_wrap;
        cfg_in.hold2      = cfg_hold2;
        cfg_in.wait_early = cfg_wait_early;
    end

    bseq_cfg_latch #(.LAT_W(LAT_W)) u_cfg (
        .clk(clk), .rst(rst), .load(strobe), .cfg_in(cfg_in), .lat_code(cfg_lat_code),
        .cfg_q(cfg_q), .lat_dec(lat_dec), .lat_bad(lat_illegal)
    );

    bseq_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst(rst), .load(strobe), .start(start_addr), .adv(adv),
        .len(cfg_q.len), .linear(is_linear(cfg_q)), .addr_q(arr_addr), .last(last)
    );

    bseq_ctrl #(.LAT_W(LAT_W)) u_ctrl (
        .clk(clk), .rst(rst), .chip_en(chip_en), .strobe(strobe), .lat_dec(lat_dec),
        .hold2(cfg_q.hold2), .wait_early(cfg_q.wait_early), .last(last),
        .st_q(st_q), .ph_q(ph_q), .adv(adv), .wait_act(wait_act)
    );

    bseq_wait_drv u_wait (
        .chip_en(chip_en), .out_en(out_en), .wait_act(wait_act), .wait_hi(cfg_wait_hi),
        .wait_out(wait_out), .wait_oe(wait_oe)
    );

    assign data_valid = chip_en && (st_q == ST_DATA);
    assign arr_rd     = data_valid && !ph_q;

    // R1: reset leaves the port quiet
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!data_valid && !lat_illegal));

    // R11: a deselected cycle kills the burst for good
    p_abort_r11: assert property (@(posedge clk) disable iff (rst)
        !chip_en |=> !data_valid);

endmodule

// File: tb/test_burst_read_seq.sv
module test_burst_read_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chip_en = 1'b0;
    logic        out_en = 1'b0;
    logic        addr_valid = 1'b0;
    logic [22:0] start_addr = '0;
    logic [1:0]  cfg_len = 2'd3;
    logic        cfg_no_wrap = 1'b1;
    logic        cfg_hold2 = 1'b1;
    logic        cfg_wait_hi = 1'b1;
    logic        cfg_wait_early = 1'b0;
    logic [2:0]  cfg_lat_code = 3'd3;
    logic [22:0] arr_addr;
    logic        arr_rd, data_valid, wait_out, wait_oe, lat_illegal;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    burst_read_seq i_burst_read_seq (
        .clk(clk), .rst(rst), .chip_en(chip_en), .out_en(out_en), .addr_valid(addr_valid),
        .start_addr(start_addr), .cfg_len(cfg_len), .cfg_no_wrap(cfg_no_wrap),
        .cfg_hold2(cfg_hold2), .cfg_wait_hi(cfg_wait_hi), .cfg_wait_early(cfg_wait_early),
        .cfg_lat_code(cfg_lat_code), .arr_addr(arr_addr), .arr_rd(arr_rd),
        .data_valid(data_valid), .wait_out(wait_out), .wait_oe(wait_oe),
        .lat_illegal(lat_illegal)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [22:0] nxt(logic [22:0] a, logic [1:0] len, logic nowrap);
        int sz;
        if (len == 2'd3 || nowrap) return a + 23'd1;
        sz = 4 << len;
        return (a & ~23'(sz - 1)) | ((a + 23'd1) & 23'(sz - 1));
    endfunction

    task automatic run_burst(input logic [22:0] start, input logic [1:0] len, input logic nowrap,
                             input logic hold2, input logic [2:0] code, input logic whi,
                             input logic wearly, input logic oe, input int nwords,
                             input bit abort, input string tag);
        int L     = (code < 3'd2) ? 7 : int'(code);
        int H     = hold2 ? 2 : 1;
        int words = (len == 2'd3 || abort) ? nwords : (4 << len);
        logic [22:0] a = start;
        @(negedge clk);
        chip_en = 1'b1; out_en = oe; addr_valid = 1'b1; start_addr = start;
        cfg_len = len; cfg_no_wrap = nowrap; cfg_hold2 = hold2; cfg_lat_code = code;
        cfg_wait_hi = whi; cfg_wait_early = wearly;
        @(negedge clk);
        addr_valid = 1'b0;
        // scramble every sampled field after the strobe
        cfg_len = ~len; cfg_no_wrap = ~nowrap; cfg_hold2 = ~hold2;
        cfg_wait_early = ~wearly; cfg_lat_code = ~code; start_addr = ~start;
        #1;
        chk("R2", "illegal flag", int'(lat_illegal), int'(code < 3'd2));
        for (int k = 1; k < L; k++) begin
            chk("R2", "no data during latency", int'(data_valid), 0);
            chk("R10", "wait enable", int'(wait_oe), int'(oe));
            if (oe) begin
                bit act = (k < L - (wearly ? 1 : 0));
                chk(wearly ? "R9" : "R8", "wait level in latency", int'(wait_out),
                    int'(act ? whi : !whi));
            end else begin
                chk("R10", "wait idle when disabled", int'(wait_out), 0);
            end
            @(negedge clk); #1;
        end
        for (int w = 0; w < words; w++) begin
            for (int h = 0; h < H; h++) begin
                chk("R7", "data valid", int'(data_valid), 1);
                chk("R7", "read strobe", int'(arr_rd), int'(h == 0));
                chk(tag, "address", int'(arr_addr), int'(a));
                if (oe) chk("R8", "wait released in data", int'(wait_out), int'(!whi));
                @(negedge clk); #1;
            end
            a = nxt(a, len, nowrap);
        end
        if (len == 2'd3 || abort) begin
            chip_en = 1'b0; #1;
            chk("R11", "valid drops with enable", int'(data_valid), 0);
            chk("R11", "read drops with enable", int'(arr_rd), 0);
            chk("R10", "wait released when deselected", int'(wait_oe), 0);
            @(negedge clk);
            chip_en = 1'b1; #1;
            chk("R11", "no resume", int'(data_valid), 0);
            @(negedge clk); #1;
            chk("R11", "still idle", int'(data_valid), 0);
            chip_en = 1'b0;
        end else begin
            chk("R3", "idle after burst", int'(data_valid), 0);
            chk("R3", "no read after burst", int'(arr_rd), 0);
            chip_en = 1'b0;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0; #1;
        chk("R1", "valid after reset", int'(data_valid), 0);
        chk("R1", "read after reset", int'(arr_rd), 0);
        chk("R1", "flag after reset", int'(lat_illegal), 0);
        chk("R10", "wait enable off", int'(wait_oe), 0);
        chk("R10", "wait low when off", int'(wait_out), 0);
        @(negedge clk);
        chip_en = 1'b1; out_en = 1'b1; #1;
        chk("R10", "wait enable on", int'(wait_oe), 1);
        chk("R8", "idle wait inactive high-polarity", int'(wait_out), 0);
        chk("R1", "no data without strobe", int'(data_valid), 0);
        chip_en = 1'b0; out_en = 1'b0;
    endtask

    task automatic t_linear4();    run_burst(23'h000106, 2'd0, 1'b1, 1'b0, 3'd3, 1'b1, 1'b0, 1'b1, 0, 1'b0, "R4/R12"); endtask
    task automatic t_wrap8();      run_burst(23'h000015, 2'd1, 1'b0, 1'b0, 3'd2, 1'b1, 1'b0, 1'b1, 0, 1'b0, "R5"); endtask
    task automatic t_wrap16_h2();  run_burst(23'h00003E, 2'd2, 1'b0, 1'b1, 3'd4, 1'b1, 1'b0, 1'b1, 0, 1'b0, "R5"); endtask
    task automatic t_cont();       run_burst(23'h00007E, 2'd3, 1'b0, 1'b0, 3'd5, 1'b1, 1'b0, 1'b1, 20, 1'b0, "R6"); endtask
    task automatic t_cont_h2();    run_burst(23'h7FFFFE, 2'd3, 1'b1, 1'b1, 3'd2, 1'b0, 1'b0, 1'b1, 5, 1'b0, "R6"); endtask
    task automatic t_wait_low();   run_burst(23'h000200, 2'd0, 1'b1, 1'b0, 3'd6, 1'b0, 1'b1, 1'b1, 0, 1'b0, "R4"); endtask
    task automatic t_wait_early(); run_burst(23'h000031, 2'd0, 1'b0, 1'b1, 3'd4, 1'b1, 1'b1, 1'b1, 0, 1'b0, "R5"); endtask
    task automatic t_oe_off();     run_burst(23'h000400, 2'd0, 1'b1, 1'b0, 3'd3, 1'b1, 1'b0, 1'b0, 0, 1'b0, "R4"); endtask
    task automatic t_abort();      run_burst(23'h000050, 2'd1, 1'b0, 1'b0, 3'd2, 1'b1, 1'b0, 1'b1, 1, 1'b1, "R11"); endtask
    task automatic t_reserved0();  run_burst(23'h000010, 2'd0, 1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 0, 1'b0, "R2"); endtask
    task automatic t_reserved1();  run_burst(23'h000020, 2'd0, 1'b0, 1'b0, 3'd1, 1'b1, 1'b1, 1'b1, 0, 1'b0, "R2"); endtask
    task automatic t_legal_clear();run_burst(23'h000044, 2'd0, 1'b0, 1'b0, 3'd7, 1'b1, 1'b0, 1'b1, 0, 1'b0, "R2"); endtask

    initial begin
        t_reset();
        t_linear4();
        t_wrap8();
        t_wrap16_h2();
        t_cont();
        t_cont_h2();
        t_wait_low();
        t_wait_early();
        t_oe_off();
        t_abort();
        t_reserved0();
        t_reserved1();
        t_legal_clear();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule